// File: doc/BRIEF.md
# DMA Channel Status Command Decoder

This block keeps the per-channel status of a 32-channel DMA engine: a START request bit per channel, a DONE bit per channel and an interrupt-request flag per channel. Software does not read-modify-write these bits. It writes encoded command bytes instead. One byte lane of the command word sets a channel's START bit and another lane clears a channel's DONE bit. A single 32-bit store can therefore carry both commands, and every lane is decoded on its own.

Each command byte holds an ignore flag in bit 7 and a 7-bit code in bits 6:0.
- Codes 0..31 name a single channel.
- Codes 32..63 are reserved and do nothing.
- Codes 64..127 address every channel at once.

A START bit lasts exactly one cycle and is issued to the engine as a service-request pulse. The engine drives the hardware inputs that set DONE bits and interrupt flags. The interrupt bitmap is readable and is cleared by writing ones to it.

Top module: `dma_chan_status`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `svc_req_o`, `irq_pending_o` and the interrupt bitmap read at `rd_sel`=1 are all zero.
- R2: A command byte with bit 7 set changes no START or DONE bit.
- R3: A write to `bus_sel`=0 with lane 0 enabled, bit 7 clear and code 0..31 raises only that channel's `svc_req_o` bit, in the cycle after the write clock edge, for exactly one cycle.
- R4: A write to `bus_sel`=0 with lane 1 (bits 15:8) enabled, bit 15 clear and code 0..31 clears only that channel's DONE bit, visible after the write edge.
- R5: Codes 32..63 in either command lane change no state.
- R6: Codes 64..127 raise `svc_req_o` on all 32 channels (lane 0) or clear every DONE bit (lane 1).
- R7: A lane whose byte enable is low acts as an ignored command. Lanes 2 and 3 of the command word have no effect.
- R8: Reading with `rd_sel`=0 (the command word) returns all zeros.
- R9: A high `hw_done_set` bit sets that DONE bit at the next edge. It wins over a software clear of the same channel in the same cycle.
- R10: A high `hw_irq_set` bit sets that bitmap bit. A write to `bus_sel`=1 clears every bitmap bit whose data bit is 1 and whose byte enable is high. A hardware set in the same cycle wins. `rd_sel`=1 reads the bitmap, and `irq_pending_o` is the OR of it.
- R11: Both command lanes of one write take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | Write target: 0 command word, 1 interrupt bitmap |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 command word, 1 interrupt bitmap |
| bus_rdata | output | 32 | Read data |
| hw_done_set | input | 32 | Engine marks channels done |
| hw_irq_set | input | 32 | Engine raises channel interrupts |
| done_o | output | 32 | DONE bits |
| svc_req_o | output | 32 | One-cycle service-request pulses |
| irq_pending_o | output | 1 | Any interrupt flag set |

## Verification
Two pairs of events can fall in the same cycle. A software DONE clear can meet an engine DONE set on the same channel, and a write-one-to-clear of the bitmap can meet an engine interrupt set on the same bit. The bench provokes both with directed cases aimed at one channel. It also provokes them with random cycles in which random engine inputs overlap random commands. Each result is judged against a bench model in which the hardware set is applied after the software clear.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [1:0] {
    CK_IGNORE = 2'd0,
    CK_SINGLE = 2'd1,
    CK_ALL    = 2'd2,
    CK_RSVD   = 2'd3
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic en, input logic [CMD_W-1:0] b);
    cmd_kind_e k;
    if (!en || b[7])  k = CK_IGNORE;
    else if (b[6])    k = CK_ALL;
    else if (b[5])    k = CK_RSVD;
    else              k = CK_SINGLE;
    return k;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/cmd_lane_decode.sv
module cmd_lane_decode
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              lane_en,
  input  logic [CMD_W-1:0]  cmd_byte,
  output logic [NUM_CH-1:0] chan_mask
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  cmd_kind_e       kind;
  logic [CH_W-1:0] idx;

  assign kind = classify(lane_en, cmd_byte);
  assign idx  = cmd_byte[CH_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chan_mask[i] = (kind == CK_ALL) ||
                          ((kind == CK_SINGLE) && (idx == CH_W'(i)));
  end

  // Reserved codes and ignored bytes must never select a channel.
  always_comb begin
    if (lane_en === 1'b1 && cmd_byte[7] === 1'b1)
      assert_nop_quiet_R2: assert (chan_mask == '0);
    if (lane_en === 1'b1 && cmd_byte[7:5] === 3'b001)
      assert_rsvd_quiet_R5: assert (chan_mask == '0);
  end
endmodule

// File: rtl/start_pulse_bank.sv
module start_pulse_bank #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_mask,
  output logic [NUM_CH-1:0] pulse_q
);
  logic [NUM_CH-1:0] pulse_d;

  // Self-clearing: a bit survives one cycle unless commanded again.
  always_comb begin
    pulse_d = set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end
endmodule

// File: rtl/done_status_bank.sv
module done_status_bank #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] hw_set,
  output logic [NUM_CH-1:0] done_q
);
  logic [NUM_CH-1:0] done_d;
  logic              done_en;

  assign done_en = (|clr_mask) || (|hw_set);

  always_comb begin
    done_d = done_q;
    if (done_en) done_d = (done_q & ~clr_mask) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= done_d;
  end

  assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((done_q & $past(hw_set)) == $past(hw_set)));

  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~hw_set)) |=> ((done_q & $past(clr_mask & ~hw_set)) == '0));

  assert_rise_only_by_hw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((done_q & ~$past(done_q) & ~$past(hw_set)) == '0));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] w1c_mask,
  input  logic [NUM_CH-1:0] hw_set,
  output logic [NUM_CH-1:0] flag_q
);
  logic [NUM_CH-1:0] flag_d;
  logic              flag_en;

  assign flag_en = (|w1c_mask) || (|hw_set);

  always_comb begin
    flag_d = flag_q;
    if (flag_en) flag_d = (flag_q & ~w1c_mask) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assert_irq_hw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));

  assert_irq_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c_mask & ~hw_set)) |=> ((flag_q & $past(w1c_mask & ~hw_set)) == '0));
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH     = 32,
  parameter int unsigned START_LANE = 0,
  parameter int unsigned DONE_LANE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [NUM_CH/8-1:0] bus_be,
  input  logic [NUM_CH-1:0] bus_wdata,
  input  logic              rd_sel,
  output logic [NUM_CH-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] hw_done_set,
  input  logic [NUM_CH-1:0] hw_irq_set,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] svc_req_o,
  output logic              irq_pending_o
);
  localparam int unsigned BUS_W = NUM_CH;
  localparam int unsigned LANES = BUS_W / CMD_W;

  logic              rst_n_s;
  logic              cmd_wr;
  logic              map_wr;
  logic [BUS_W-1:0]  be_bits;
  logic [NUM_CH-1:0] start_mask;
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] w1c_mask;
  logic [NUM_CH-1:0] irq_map;

  rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign cmd_wr = bus_wr && !bus_sel;
  assign map_wr = bus_wr &&  bus_sel;

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_bits[l*CMD_W +: CMD_W] = {CMD_W{bus_be[l]}};
  end

  cmd_lane_decode #(.NUM_CH(NUM_CH)) u_start_dec (
    .lane_en   (cmd_wr && bus_be[START_LANE]),
    .cmd_byte  (bus_wdata[START_LANE*CMD_W +: CMD_W]),
    .chan_mask (start_mask)
  );

  cmd_lane_decode #(.NUM_CH(NUM_CH)) u_done_dec (
    .lane_en   (cmd_wr && bus_be[DONE_LANE]),
    .cmd_byte  (bus_wdata[DONE_LANE*CMD_W +: CMD_W]),
    .chan_mask (clr_mask)
  );

  assign w1c_mask = map_wr ? (bus_wdata & be_bits) : '0;

  start_pulse_bank #(.NUM_CH(NUM_CH)) u_start (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_mask (start_mask),
    .pulse_q  (svc_req_o)
  );

  done_status_bank #(.NUM_CH(NUM_CH)) u_done (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_mask (clr_mask),
    .hw_set   (hw_done_set),
    .done_q   (done_o)
  );

  irq_flag_bank #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .w1c_mask (w1c_mask),
    .hw_set   (hw_irq_set),
    .flag_q   (irq_map)
  );

  // Command word is write-only; only the bitmap reads back.
  assign bus_rdata     = rd_sel ? irq_map : '0;
  assign irq_pending_o = |irq_map;

  assert_pulse_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cmd_wr |=> (svc_req_o == '0));

  assert_map_write_leaves_done_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (map_wr && hw_done_set == '0) |=> $stable(done_o));

  assert_start_nop_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_wr && bus_wdata[START_LANE*CMD_W+7]) |=> (svc_req_o == '0));
endmodule

// File: tb/dma_chan_status_tb.sv
module dma_chan_status_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_sel, rd_sel;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata, hw_done_set, hw_irq_set, done_o, svc_req_o;
  logic        irq_pending_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] m_done, m_irq, m_svc;

  always #5 clk = ~clk;

  dma_chan_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .rd_sel(rd_sel), .bus_rdata(bus_rdata),
    .hw_done_set(hw_done_set), .hw_irq_set(hw_irq_set), .done_o(done_o),
    .svc_req_o(svc_req_o), .irq_pending_o(irq_pending_o)
  );

  function automatic logic [31:0] cmd_mask(input logic [7:0] b, input logic en);
    if (!en || b[7]) return 32'h0;
    if (b[6])        return 32'hFFFF_FFFF;
    if (b[5])        return 32'h0;
    return 32'h1 << b[4:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic sel, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] hd, input logic [31:0] hi,
                     input string tag);
    logic [31:0] cm, bem;
    bem = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    m_svc = cmd_mask(wd[7:0], wr && !sel && be[0]);
    cm    = cmd_mask(wd[15:8], wr && !sel && be[1]);
    m_done = (m_done & ~cm) | hd;
    m_irq  = (m_irq & ~((wr && sel) ? (wd & bem) : 32'h0)) | hi;
    bus_wr = wr; bus_sel = sel; bus_be = be; bus_wdata = wd;
    hw_done_set = hd; hw_irq_set = hi;
    @(posedge clk); #1;
    bus_wr = 1'b0; hw_done_set = '0; hw_irq_set = '0;
    chk({tag, " done"}, done_o, m_done);
    chk({tag, " svc"},  svc_req_o, m_svc);
    rd_sel = 1'b1; #1;
    chk({tag, " irq map"}, bus_rdata, m_irq);
    chk({tag, " irq pending"}, {31'h0, irq_pending_o}, {31'h0, |m_irq});
  endtask

  initial begin
    int cyc_cnt = 0;
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc_cnt);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_wr = 0; bus_sel = 0; rd_sel = 1; bus_be = 0; bus_wdata = 0;
    hw_done_set = 0; hw_irq_set = 0;
    m_done = 0; m_irq = 0; m_svc = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset done", done_o, 0);
    chk("R1 reset svc", svc_req_o, 0);
    chk("R1 reset irq", bus_rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 post-release done", done_o, 0);

    // Fill DONE from hardware, then exercise the clear commands.
    cyc(0, 0, 4'h0, 0, 32'hFFFF_FFFF, 32'h0, "R9 hw set all");
    cyc(1, 0, 4'h3, 32'h0000_0503, 0, 0, "R3 R4 R11 single start/clear");
    cyc(1, 0, 4'h3, 32'h0000_8A8B, 0, 0, "R2 nop lanes");
    cyc(1, 0, 4'h3, 32'h0000_2A3F, 0, 0, "R5 reserved codes");
    cyc(1, 0, 4'h1, 32'h0000_0700, 0, 0, "R7 lane1 disabled");
    cyc(1, 0, 4'hC, 32'h4040_0000, 0, 0, "R7 lanes 2 3 inert");
    cyc(1, 0, 4'h2, 32'h0000_1F00, 32'h8000_0000, 0, "R9 hw wins over clear");
    cyc(1, 0, 4'h1, 32'h0000_001F, 0, 0, "R3 top channel");
    cyc(1, 0, 4'h3, 32'h0000_7F40, 0, 0, "R6 global start and clear");
    cyc(0, 0, 4'h0, 0, 0, 0, "R3 pulse self-clears");

    // Interrupt bitmap.
    cyc(0, 0, 4'h0, 0, 0, 32'hA5A5_F00F, "R10 hw irq set");
    cyc(1, 1, 4'h1, 32'hFFFF_FFFF, 0, 0, "R10 w1c lane0");
    cyc(1, 1, 4'hF, 32'h0000_F000, 0, 32'h0000_1000, "R10 hw wins over w1c");
    rd_sel = 1'b0; #1;
    chk("R8 command word reads zero", bus_rdata, 0);
    rd_sel = 1'b1;

    for (int i = 0; i < 400; i++) begin
      logic [31:0] wd, hd, hi;
      logic [3:0]  be;
      wd = $urandom; be = 4'($urandom);
      hd = ($urandom % 4 == 0) ? $urandom : 32'h0;
      hi = ($urandom % 4 == 0) ? $urandom : 32'h0;
      if ($urandom % 3 == 0) begin
        hd = hd | (32'h1 << wd[12:8]);
        hi = hi | wd;
      end
      cyc(1'($urandom), 1'($urandom), be, wd, hd, hi, "R2 R3 R4 R5 R6 R9 R10 random");
      if (i % 50 == 0) begin
        rd_sel = 1'b0; #1;
        chk("R8 random read zero", bus_rdata, 0);
        rd_sel = 1'b1;
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule